// File: doc/BRIEF.md
# I2C Host/Client Activity Status Tracker

This block holds the status picture of a combined I2C host/client controller. The bus monitor, the client engine and the host engine each report what they see as single-cycle pulses. Examples are a START or STOP seen on the wires, a client address that matched or missed, a NACK, a collision, a timeout and a CRC or framing fault. The block turns these pulses into two level flags, one telling whether the client engine is inside a transaction and one telling whether the host engine is. It also keeps nine sticky event and error flags, and a single combined error bit.

Software reads the sticky flags and clears them by writing ones to a clear port. Bus signalling, timeout counting and CRC arithmetic are done elsewhere and arrive here only as pulses. All outputs are registered. An input pulse seen at a rising edge shows up on the outputs right after that edge.

Top module: `i2c_status_tracker`

## Requirements
- R1: A pulse on `cli_addr_match` (the eighth falling SCL edge of a matching client address) sets `cli_active` after the same edge.
- R2: `cli_active` clears after an edge where any of these is pulsed: `bus_stop`, `err_scl_to`, `err_bus_coll`, `cli_nack`.
- R3: `cli_active` also clears on `cli_miss_10b` (address miss in 10-bit addressing), on `cli_miss_rs` (address miss after a repeated START), and on `cli_crc_idle` (client back to idle after the ACK/NACK of the CRC byte).
- R4: When a set and a clear of the same active flag arrive in one cycle, the flag ends up cleared.
- R5: A pulse on `host_start` (the host drives a START) sets `host_active`.
- R6: `host_active` clears on `err_bus_coll` or on `host_stop_done` (the host has sent its STOP). An SCL timeout on its own leaves `host_active` set until that STOP has been sent.
- R7: `flags` bit positions: 0 start seen, 1 stop seen, 2 SCL timeout, 3 client cumulative timeout, 4 host cumulative timeout, 5 frame error, 6 CRC error, 7 bus collision, 8 NACK error. `err_any` is high exactly when any of bits 2 to 8 is high.
- R8: Each flag bit is set by its input pulse and stays set. A cycle with `sw_clr_we` high clears every bit whose `sw_clr_mask` bit is 1 and leaves the other bits as they are.
- R9: When a hardware set and a software clear of the same flag bit fall in one cycle, the bit ends up set.
- R10: A synchronous active-high `rst` clears `cli_active`, `host_active`, `flags` and `err_any`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_start | input | 1 | START seen on bus (pulse) |
| bus_stop | input | 1 | STOP seen on bus (pulse) |
| cli_addr_match | input | 1 | Client address matched (pulse) |
| cli_miss_10b | input | 1 | Client address miss, 10-bit mode (pulse) |
| cli_miss_rs | input | 1 | Client address miss after repeated START (pulse) |
| cli_nack | input | 1 | NACK sent or received by client (pulse) |
| cli_crc_idle | input | 1 | Client idle after CRC byte ACK/NACK (pulse) |
| host_start | input | 1 | Host drove START (pulse) |
| host_stop_done | input | 1 | Host finished sending STOP (pulse) |
| err_bus_coll | input | 1 | Bus collision (pulse) |
| err_scl_to | input | 1 | SCL timeout (pulse) |
| err_cli_cto | input | 1 | Client cumulative timeout (pulse) |
| err_host_cto | input | 1 | Host cumulative timeout (pulse) |
| err_frame | input | 1 | Frame error (pulse) |
| err_crc | input | 1 | CRC error (pulse) |
| err_nack | input | 1 | NACK treated as error (pulse) |
| sw_clr_we | input | 1 | Software clear strobe |
| sw_clr_mask | input | 9 | Write-one-to-clear mask over `flags` |
| cli_active | output | 1 | Client transaction in progress |
| host_active | output | 1 | Host transaction in progress |
| flags | output | 9 | Sticky event and error flags |
| err_any | output | 1 | OR of the error flags |

## Verification
Two kinds of same-cycle collision matter here. One is a set and a clear of an active flag, for example an address match together with a STOP, or a host START together with a host STOP done, and these must resolve to cleared. The other is a hardware pulse on a sticky flag together with a software clear whose mask covers it, and these must resolve to set. The stimulus table drives both pairs in a single cycle. The flag is judged on the cycle after the edge, and in the mixed case a bit in the same mask that has no pulse must still clear.

// File: rtl/i2c_status_pkg.sv
package i2c_status_pkg;
  localparam int FLAG_W   = 9;
  localparam int F_START  = 0;
  localparam int F_STOP   = 1;
  localparam int F_SCLTO  = 2;
  localparam int F_CCTO   = 3;
  localparam int F_HCTO   = 4;
  localparam int F_FRAME  = 5;
  localparam int F_CRC    = 6;
  localparam int F_COLL   = 7;
  localparam int F_NACKE  = 8;
  localparam int ERR_LO   = F_SCLTO;
  localparam int ERR_HI   = F_NACKE;
  localparam logic [FLAG_W-1:0] ERR_MASK =
    FLAG_W'(((1 << (ERR_HI - ERR_LO + 1)) - 1) << ERR_LO);
endpackage

// File: rtl/i2c_active_flag.sv
module i2c_active_flag #(
  parameter int SET_N = 1,
  parameter int CLR_N = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_N-1:0] set_src,
  input  logic [CLR_N-1:0] clr_src,
  output logic             active
);
  logic any_set, any_clr;

  always_comb begin
    any_set = |set_src;
    any_clr = |clr_src;
  end

  always_ff @(posedge clk) begin
    if (rst)          active <= 1'b0;
    else if (any_clr) active <= 1'b0;
    else if (any_set) active <= 1'b1;
  end
endmodule

// File: rtl/i2c_sticky_bank.sv
module i2c_sticky_bank #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hw_set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (hw_set[i])                   q_nxt[i] = 1'b1;
      else if (clr_we && clr_mask[i])  q_nxt[i] = 1'b0;
      else                             q_nxt[i] = q[i];
    end

    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= q_nxt[i];
    end
  end
endmodule

// File: rtl/i2c_status_tracker.sv
module i2c_status_tracker
  import i2c_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              cli_addr_match,
  input  logic              cli_miss_10b,
  input  logic              cli_miss_rs,
  input  logic              cli_nack,
  input  logic              cli_crc_idle,
  input  logic              host_start,
  input  logic              host_stop_done,
  input  logic              err_bus_coll,
  input  logic              err_scl_to,
  input  logic              err_cli_cto,
  input  logic              err_host_cto,
  input  logic              err_frame,
  input  logic              err_crc,
  input  logic              err_nack,
  input  logic              sw_clr_we,
  input  logic [FLAG_W-1:0] sw_clr_mask,
  output logic              cli_active,
  output logic              host_active,
  output logic [FLAG_W-1:0] flags,
  output logic              err_any
);
  localparam int CLI_CLR_N  = 7;
  localparam int HOST_CLR_N = 2;

  logic [CLI_CLR_N-1:0]  cli_clr;
  logic [HOST_CLR_N-1:0] host_clr;
  logic [FLAG_W-1:0]     hw_set;
  logic [FLAG_W-1:0]     flags_nxt;

  always_comb begin
    cli_clr  = {bus_stop, err_scl_to, err_bus_coll, cli_nack,
                cli_miss_10b, cli_miss_rs, cli_crc_idle};
    host_clr = {err_bus_coll, host_stop_done};
    hw_set          = '0;
    hw_set[F_START] = bus_start;
    hw_set[F_STOP]  = bus_stop;
    hw_set[F_SCLTO] = err_scl_to;
    hw_set[F_CCTO]  = err_cli_cto;
    hw_set[F_HCTO]  = err_host_cto;
    hw_set[F_FRAME] = err_frame;
    hw_set[F_CRC]   = err_crc;
    hw_set[F_COLL]  = err_bus_coll;
    hw_set[F_NACKE] = err_nack;
  end

  i2c_active_flag #(.SET_N(1), .CLR_N(CLI_CLR_N)) u_cli (
    .clk(clk), .rst(rst), .set_src(cli_addr_match),
    .clr_src(cli_clr), .active(cli_active)
  );

  i2c_active_flag #(.SET_N(1), .CLR_N(HOST_CLR_N)) u_host (
    .clk(clk), .rst(rst), .set_src(host_start),
    .clr_src(host_clr), .active(host_active)
  );

  i2c_sticky_bank #(.W(FLAG_W)) u_bank (
    .clk(clk), .rst(rst), .hw_set(hw_set), .clr_we(sw_clr_we),
    .clr_mask(sw_clr_mask), .q(flags), .q_nxt(flags_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) err_any <= 1'b0;
    else     err_any <= |(flags_nxt & ERR_MASK);
  end
endmodule

// File: rtl/i2c_status_tracker_chk.sv
module i2c_status_tracker_chk
  import i2c_status_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_start,
  input logic              bus_stop,
  input logic              cli_addr_match,
  input logic              cli_miss_10b,
  input logic              cli_miss_rs,
  input logic              cli_nack,
  input logic              cli_crc_idle,
  input logic              host_start,
  input logic              host_stop_done,
  input logic              err_bus_coll,
  input logic              err_scl_to,
  input logic              sw_clr_we,
  input logic [FLAG_W-1:0] sw_clr_mask,
  input logic              cli_active,
  input logic              host_active,
  input logic [FLAG_W-1:0] flags,
  input logic              err_any
);
  logic cli_kill, cli_kill_proto;
  always_comb begin
    cli_kill       = bus_stop | err_scl_to | err_bus_coll | cli_nack;
    cli_kill_proto = cli_miss_10b | cli_miss_rs | cli_crc_idle;
  end

  AST_CLI_SET: assert property (@(posedge clk) disable iff (rst)
    cli_addr_match && !cli_kill && !cli_kill_proto |=> cli_active); // R1
  AST_CLI_CLR_BUS: assert property (@(posedge clk) disable iff (rst)
    cli_kill |=> !cli_active); // R2
  AST_CLI_CLR_PROTO: assert property (@(posedge clk) disable iff (rst)
    cli_kill_proto |=> !cli_active); // R3
  AST_SET_CLR_TIE: assert property (@(posedge clk) disable iff (rst)
    host_start && host_stop_done |=> !host_active); // R4
  AST_HOST_SET: assert property (@(posedge clk) disable iff (rst)
    host_start && !host_stop_done && !err_bus_coll |=> host_active); // R5
  AST_HOST_CLR: assert property (@(posedge clk) disable iff (rst)
    host_stop_done || err_bus_coll |=> !host_active); // R6
  AST_HOST_HOLD_TO: assert property (@(posedge clk) disable iff (rst)
    host_active && err_scl_to && !host_stop_done && !err_bus_coll
    |=> host_active); // R6
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    err_any == |(flags & ERR_MASK)); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sw_clr_we && sw_clr_mask[F_START] && !bus_start |=> !flags[F_START]); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> flags[F_START]); // R9
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> !cli_active && !host_active && flags == '0 && !err_any); // R10
endmodule

bind i2c_status_tracker i2c_status_tracker_chk u_chk (
  .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
  .cli_addr_match(cli_addr_match), .cli_miss_10b(cli_miss_10b),
  .cli_miss_rs(cli_miss_rs), .cli_nack(cli_nack), .cli_crc_idle(cli_crc_idle),
  .host_start(host_start), .host_stop_done(host_stop_done),
  .err_bus_coll(err_bus_coll), .err_scl_to(err_scl_to),
  .sw_clr_we(sw_clr_we), .sw_clr_mask(sw_clr_mask),
  .cli_active(cli_active), .host_active(host_active),
  .flags(flags), .err_any(err_any)
);

// File: tb/i2c_status_tracker_test.sv
module i2c_status_tracker_test;
  logic clk = 1'b0;
  logic rst;
  logic [15:0] ev;
  logic        we;
  logic [8:0]  mask;
  logic        cli_active, host_active, err_any;
  logic [8:0]  flags;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // ev bits: 15 start,14 stop,13 match,12 miss10,11 missrs,10 nack,9 crcidle,
  // 8 hstart,7 hstop,6 coll,5 sclto,4 clicto,3 hostcto,2 frame,1 crc,0 nackerr
  i2c_status_tracker uut (
    .clk(clk), .rst(rst),
    .bus_start(ev[15]), .bus_stop(ev[14]), .cli_addr_match(ev[13]),
    .cli_miss_10b(ev[12]), .cli_miss_rs(ev[11]), .cli_nack(ev[10]),
    .cli_crc_idle(ev[9]), .host_start(ev[8]), .host_stop_done(ev[7]),
    .err_bus_coll(ev[6]), .err_scl_to(ev[5]), .err_cli_cto(ev[4]),
    .err_host_cto(ev[3]), .err_frame(ev[2]), .err_crc(ev[1]),
    .err_nack(ev[0]), .sw_clr_we(we), .sw_clr_mask(mask),
    .cli_active(cli_active), .host_active(host_active),
    .flags(flags), .err_any(err_any)
  );

  // row: {ev[15:0], we, mask[8:0], exp_cli, exp_host, exp_flags[8:0], exp_err}
  localparam int ROWS = 21;
  localparam logic [37:0] VEC [ROWS] = '{
    {16'h2000, 1'b0, 9'h000, 1'b1, 1'b0, 9'h000, 1'b0}, // R1 match
    {16'h0100, 1'b0, 9'h000, 1'b1, 1'b1, 9'h000, 1'b0}, // R5 host start
    {16'h0020, 1'b0, 9'h000, 1'b0, 1'b1, 9'h004, 1'b1}, // R2 R6 R7 scl timeout
    {16'h0080, 1'b0, 9'h000, 1'b0, 1'b0, 9'h004, 1'b1}, // R6 host stop done
    {16'h0000, 1'b1, 9'h004, 1'b0, 1'b0, 9'h000, 1'b0}, // R8 R7 w1c
    {16'h6000, 1'b0, 9'h000, 1'b0, 1'b0, 9'h002, 1'b0}, // R4 R2 match+stop
    {16'h2000, 1'b0, 9'h000, 1'b1, 1'b0, 9'h002, 1'b0}, // R1
    {16'h0800, 1'b0, 9'h000, 1'b0, 1'b0, 9'h002, 1'b0}, // R3 miss after restart
    {16'hA000, 1'b1, 9'h003, 1'b1, 1'b0, 9'h001, 1'b0}, // R9 R8 set wins
    {16'h0200, 1'b0, 9'h000, 1'b0, 1'b0, 9'h001, 1'b0}, // R3 crc idle
    {16'h2100, 1'b0, 9'h000, 1'b1, 1'b1, 9'h001, 1'b0}, // R1 R5
    {16'h0040, 1'b0, 9'h000, 1'b0, 1'b0, 9'h081, 1'b1}, // R2 R6 R7 collision
    {16'h0000, 1'b1, 9'h1FF, 1'b0, 1'b0, 9'h000, 1'b0}, // R8 clear all
    {16'h001F, 1'b0, 9'h000, 1'b0, 1'b0, 9'h178, 1'b1}, // R7 five errors
    {16'h0180, 1'b0, 9'h000, 1'b0, 1'b0, 9'h178, 1'b1}, // R4 hstart+hstop
    {16'h2400, 1'b0, 9'h000, 1'b0, 1'b0, 9'h178, 1'b1}, // R4 R2 match+nack
    {16'h2000, 1'b0, 9'h000, 1'b1, 1'b0, 9'h178, 1'b1}, // R1
    {16'h1000, 1'b0, 9'h000, 1'b0, 1'b0, 9'h178, 1'b1}, // R3 10-bit miss
    {16'h0000, 1'b1, 9'h100, 1'b0, 1'b0, 9'h078, 1'b1}, // R8 partial clear
    {16'h0000, 1'b0, 9'h1FF, 1'b0, 1'b0, 9'h078, 1'b1}, // R8 mask without strobe
    {16'h0000, 1'b1, 9'h078, 1'b0, 1'b0, 9'h000, 1'b0}  // R7 R8 summary drops
  };

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got {cli,host,flags,err}=%03h expected %03h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] outs();
    return {cli_active, host_active, flags, err_any};
  endfunction

  task automatic drive(input logic [15:0] e, input logic w, input logic [8:0] m);
    @(negedge clk);
    ev = e; we = w; mask = m;
    @(negedge clk);
    ev = '0; we = 1'b0; mask = '0;
  endtask

  initial begin
    rst = 1'b1; ev = '0; we = 1'b0; mask = '0;
    repeat (3) @(negedge clk);
    check("R10 reset state", outs(), 12'h000);
    rst = 1'b0;
    for (int i = 0; i < ROWS; i++) begin
      drive(VEC[i][37:22], VEC[i][21], VEC[i][20:12]);
      check($sformatf("row %0d (see table tag)", i), outs(), VEC[i][11:0]);
    end
    // R6: repeated SCL timeouts never drop host_active before STOP done
    drive(16'h0100, 1'b0, 9'h000);
    drive(16'h0020, 1'b0, 9'h000);
    drive(16'h0020, 1'b0, 9'h000);
    check("R6 host held after timeouts", outs(), {1'b0, 1'b1, 9'h004, 1'b1});
    // R9: every bit set and cleared together stays set
    drive(16'hC07F, 1'b1, 9'h1FF);
    check("R9 all set vs clear-all", outs(), {1'b0, 1'b0, 9'h1FF, 1'b1});
    // R10: reset in the middle of activity
    drive(16'h2100, 1'b0, 9'h000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10 mid-run reset", outs(), 12'h000);
    rst = 1'b0;
    // R10: pulses during reset are dropped
    @(negedge clk); rst = 1'b1; ev = 16'hFFFF;
    @(negedge clk); ev = '0; rst = 1'b0;
    check("R10 pulses under reset", outs(), 12'h000);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule